// File: doc/BRIEF.md
# Variable-Precision Multiply-Accumulate Slice

This block is one arithmetic slice for a signal-processing datapath. A mode input divides its multiplier resources three ways: three independent signed 9x9 products, two signed 18x19 products that are summed, or one signed 27x27 product. In the two wide modes, an optional pre-adder sums a third operand into the multiplicand before the multiply. The multiplier operand can come straight from a port or from a small bank of 18-bit coefficients. Software can reload that bank while the slice runs.

In the wide modes, the product (or the sum of the two products) is sign-extended to 64 bits. It is then added to one of two independent 64-bit running sums, together with a 64-bit cascade input. That cascade input comes from the neighbouring slice. The new sum is driven on both the result and the cascade output, so several slices can be chained into a systolic filter. In the narrow mode, the three products are packed side by side on the result. In that mode the running sums and the cascade input play no part.

Each operand set is qualified by a valid input. The inputs are registered once and the result once more, so a valid result appears exactly two cycles after a valid input.

Top module: `vpm_slice`

## Requirements
- R1: While rst_n is low, out_valid is 0, result and casc_out are 0, and both running sums and all coefficient entries are cleared to 0.
- R2: out_valid is high exactly two clock edges after an edge at which in_valid was high. result changes only on cycles where out_valid is high.
- R3: With cfg_mode = 2'b00, the three signed 9-bit lanes x_in[9k+8:9k] and y_in[9k+8:9k] (k = 0,1,2) are multiplied pairwise. Product k appears on result[18k+17:18k] and result[63:54] is 0. The cascade input is ignored and neither running sum changes.
- R4: With cfg_mode = 2'b01, the slice forms two products: x_in[17:0] times y_in[18:0], and x_in[35:18] times y_in[37:19]. Their signed sum, sign-extended to 64 bits, is the product term.
- R5: With cfg_mode = 2'b10 (2'b11 behaves the same), the product term is the signed product of x_in[26:0] and y_in[26:0], sign-extended to 64 bits.
- R6: When preadd_en is 1 in modes 2'b01 and 2'b10, each multiplicand field is first widened by one bit and added to the same field of z_in. In mode 2'b00, preadd_en has no effect.
- R7: coef_we writes coef_wdata into entry coef_waddr at the clock edge. When coef_use is 1 in a wide mode, the entry at coef_sel is sign-extended and replaces every y operand. In mode 2'b00, coef_use has no effect.
- R8: In a wide mode with acc_clr = 0, the new value of the selected running sum is its old value plus the product term plus casc_in. That new value is shown on result.
- R9: With acc_clr = 1, the selected running sum is loaded with the product term plus casc_in. Its old value is discarded.
- R10: acc_sel (0 or 1) picks one of two independent running sums. The running sum that is not selected keeps its value.
- R11: casc_in is added to every wide-mode result, and casc_out always carries the same value as result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 triple 9x9, 01 dual 18x19, 10/11 single 27x27; held stable while operating |
| in_valid | input | 1 | Qualifies the operand set on this cycle |
| x_in | input | 36 | Multiplicand fields |
| y_in | input | 38 | Multiplier fields |
| z_in | input | 36 | Pre-adder operand fields |
| preadd_en | input | 1 | Add z_in to the multiplicand in the wide modes |
| coef_use | input | 1 | Take the multiplier operand from the coefficient bank |
| coef_sel | input | 3 | Coefficient bank read index |
| coef_we | input | 1 | Coefficient bank write strobe |
| coef_waddr | input | 3 | Coefficient bank write index |
| coef_wdata | input | 18 | Coefficient write data, signed |
| acc_sel | input | 1 | Selects running sum 0 or 1 |
| acc_clr | input | 1 | Load instead of accumulate |
| casc_in | input | 64 | Cascade input from the previous slice |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Accumulated sum or packed 9x9 products |
| casc_out | output | 64 | Cascade output to the next slice |

## Verification
The properties checked on every cycle are timing and format rules. They cover the clean state under reset, the two-cycle valid latency, a result that holds still between valid outputs, and the zero upper field of a packed 9x9 result. The arithmetic is shown only by the directed scenarios, because expected values depend on the data. Those scenarios cover the mode partitions, the pre-adder widening at full-scale operands, coefficient selection after run-time writes, the interplay of the two running sums with clear, and the cascade sum. Each one is compared against a model that the bench builds from the requirements.

// File: rtl/vpm_pkg.sv
`timescale 1ns/1ps
package vpm_pkg;
    localparam int ACC_W   = 64;
    localparam int COEF_W  = 18;
    localparam int N9      = 3;
    localparam int N18     = 2;
    localparam int L9_W    = 9;
    localparam int L18X_W  = 18;
    localparam int L18Y_W  = 19;
    localparam int L27_W   = 27;
    localparam int X_W     = N18 * L18X_W;
    localparam int Y_W     = N18 * L18Y_W;
    localparam int P9_W    = 2 * L9_W;
    localparam int P18_W   = 2 * L18Y_W;
    localparam int P27_W   = 2 * L27_W + 1;

    typedef enum logic [1:0] {
        MODE_TRIPLE9  = 2'b00,
        MODE_DUAL18   = 2'b01,
        MODE_SINGLE27 = 2'b10,
        MODE_ALT27    = 2'b11
    } vpm_mode_e;
endpackage

// File: rtl/vpm_coef_bank.sv
`timescale 1ns/1ps
module vpm_coef_bank #(
    parameter int DEPTH = 8,
    parameter int W     = 18,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Read returns the stored word; a same-cycle write lands after this edge.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/vpm_mult_array.sv
`timescale 1ns/1ps
module vpm_mult_array
    import vpm_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic [1:0]        mode,
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    input  logic [X_W-1:0]    z,
    input  logic              pre,
    input  logic              cu,
    input  logic [COEF_W-1:0] coef,
    output logic              triple,
    output logic [W-1:0]      sum_o,
    output logic [W-1:0]      lanes_o
);
    logic [N9*P9_W-1:0]       lanes_raw;
    logic [N18-1:0][W-1:0]    p18_ext;

    // Narrow mode: independent lanes packed side by side.
    for (genvar g = 0; g < N9; g++) begin : g_lane9
        logic signed [L9_W-1:0] a9, b9;
        logic signed [P9_W-1:0] p9;
        always_comb begin
            a9 = $signed(x[g*L9_W +: L9_W]);
            b9 = $signed(y[g*L9_W +: L9_W]);
            p9 = a9 * b9;
        end
        assign lanes_raw[g*P9_W +: P9_W] = p9;
    end
    assign lanes_o = {{(W - N9*P9_W){1'b0}}, lanes_raw};

    // Dual mode: pre-added multiplicand times direct or stored operand.
    for (genvar g = 0; g < N18; g++) begin : g_lane18
        logic signed [L18X_W-1:0] xs, zs;
        logic signed [L18Y_W-1:0] a19, b19;
        logic signed [P18_W-1:0]  p18;
        always_comb begin
            xs  = $signed(x[g*L18X_W +: L18X_W]);
            zs  = $signed(z[g*L18X_W +: L18X_W]);
            a19 = {xs[L18X_W-1], xs};
            if (pre) begin
                a19 = a19 + {zs[L18X_W-1], zs};
            end
            if (cu) begin
                b19 = {coef[COEF_W-1], coef};
            end else begin
                b19 = $signed(y[g*L18Y_W +: L18Y_W]);
            end
            p18 = a19 * b19;
        end
        assign p18_ext[g] = {{(W-P18_W){p18[P18_W-1]}}, p18};
    end

    // Single mode: one wide product with a widened pre-adder.
    logic signed [L27_W:0]   a28;
    logic signed [L27_W-1:0] b27;
    logic signed [P27_W-1:0] p27;
    logic [W-1:0]            p27_ext;
    always_comb begin
        a28 = {x[L27_W-1], x[L27_W-1:0]};
        if (pre) begin
            a28 = a28 + {z[L27_W-1], z[L27_W-1:0]};
        end
        if (cu) begin
            b27 = {{(L27_W-COEF_W){coef[COEF_W-1]}}, coef};
        end else begin
            b27 = $signed(y[L27_W-1:0]);
        end
        p27     = a28 * b27;
        p27_ext = {{(W-P27_W){p27[P27_W-1]}}, p27};
    end

    always_comb begin
        triple = (mode == MODE_TRIPLE9);
        if (mode == MODE_DUAL18) begin
            sum_o = p18_ext[0] + p18_ext[1];
        end else begin
            sum_o = p27_ext;
        end
    end
endmodule

// File: rtl/vpm_accum.sv
`timescale 1ns/1ps
module vpm_accum #(
    parameter int W      = 64,
    parameter int N_SUMS = 2,
    localparam int SW    = (N_SUMS > 1) ? $clog2(N_SUMS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          triple,
    input  logic [SW-1:0] asel,
    input  logic          clr,
    input  logic [W-1:0]  sum,
    input  logic [W-1:0]  lanes,
    input  logic [W-1:0]  casc,
    output logic          out_vld,
    output logic [W-1:0]  res
);
    typedef struct packed {
        logic                    vld;
        logic [N_SUMS-1:0][W-1:0] acc;
        logic [W-1:0]            res;
    } acc_st_t;

    acc_st_t      st_d, st_q;
    logic [W-1:0] base, total;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        base     = '0;
        total    = '0;
        if (in_vld) begin
            if (triple) begin
                st_d.res = lanes;
            end else begin
                base            = clr ? '0 : st_q.acc[asel];
                total           = base + sum + casc;
                st_d.acc[asel]  = total;
                st_d.res        = total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign res     = st_q.res;
endmodule

// File: rtl/vpm_slice.sv
`timescale 1ns/1ps
module vpm_slice
    import vpm_pkg::*;
#(
    parameter int  COEF_DEPTH = 8,
    localparam int COEF_AW    = $clog2(COEF_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               in_valid,
    input  logic [X_W-1:0]     x_in,
    input  logic [Y_W-1:0]     y_in,
    input  logic [X_W-1:0]     z_in,
    input  logic               preadd_en,
    input  logic               coef_use,
    input  logic [COEF_AW-1:0] coef_sel,
    input  logic               coef_we,
    input  logic [COEF_AW-1:0] coef_waddr,
    input  logic [COEF_W-1:0]  coef_wdata,
    input  logic               acc_sel,
    input  logic               acc_clr,
    input  logic [ACC_W-1:0]   casc_in,
    output logic               out_valid,
    output logic [ACC_W-1:0]   result,
    output logic [ACC_W-1:0]   casc_out
);
    typedef struct packed {
        logic              vld;
        logic [1:0]        mode;
        logic [X_W-1:0]    x;
        logic [Y_W-1:0]    y;
        logic [X_W-1:0]    z;
        logic              pre;
        logic              cu;
        logic [COEF_W-1:0] coef;
        logic              asel;
        logic              clr;
        logic [ACC_W-1:0]  casc;
    } in_st_t;

    in_st_t            s1_d, s1_q;
    logic [COEF_W-1:0] coef_rd;
    logic              triple;
    logic [ACC_W-1:0]  prod_sum, lanes;
    logic [ACC_W-1:0]  casc_eff;

    vpm_coef_bank #(.DEPTH(COEF_DEPTH), .W(COEF_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .waddr (coef_waddr),
        .wdata (coef_wdata),
        .raddr (coef_sel),
        .rdata (coef_rd)
    );

    // Stage 1: register the operand set with its selected coefficient.
    always_comb begin
        s1_d.vld  = in_valid;
        s1_d.mode = cfg_mode;
        s1_d.x    = x_in;
        s1_d.y    = y_in;
        s1_d.z    = z_in;
        s1_d.pre  = preadd_en;
        s1_d.cu   = coef_use;
        s1_d.coef = coef_rd;
        s1_d.asel = acc_sel;
        s1_d.clr  = acc_clr;
        s1_d.casc = casc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    vpm_mult_array #(.W(ACC_W)) u_mult (
        .mode    (s1_q.mode),
        .x       (s1_q.x),
        .y       (s1_q.y),
        .z       (s1_q.z),
        .pre     (s1_q.pre),
        .cu      (s1_q.cu),
        .coef    (s1_q.coef),
        .triple  (triple),
        .sum_o   (prod_sum),
        .lanes_o (lanes)
    );

    assign casc_eff = triple ? '0 : s1_q.casc;

    // Stage 2: accumulate into the selected running sum.
    vpm_accum #(.W(ACC_W), .N_SUMS(2)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s1_q.vld),
        .triple  (triple),
        .asel    (s1_q.asel),
        .clr     (s1_q.clr),
        .sum     (prod_sum),
        .lanes   (lanes),
        .casc    (casc_eff),
        .out_vld (out_valid),
        .res     (result)
    );

    assign casc_out = result;
endmodule

// File: rtl/vpm_slice_chk.sv
`timescale 1ns/1ps
module vpm_slice_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_mode,
    input logic        in_valid,
    input logic        out_valid,
    input logic [63:0] result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 64'd0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result));

    // R3
    triple_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_mode == 2'b00) |-> (result[63:54] == 10'd0));
endmodule

bind vpm_slice vpm_slice_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vpm_slice_tb.sv
`timescale 1ns/1ps
module vpm_slice_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        in_valid = 1'b0;
    logic [35:0] x_in = '0;
    logic [37:0] y_in = '0;
    logic [35:0] z_in = '0;
    logic        preadd_en = 1'b0;
    logic        coef_use = 1'b0;
    logic [2:0]  coef_sel = '0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_waddr = '0;
    logic [17:0] coef_wdata = '0;
    logic        acc_sel = 1'b0;
    logic        acc_clr = 1'b0;
    logic [63:0] casc_in = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [63:0] casc_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    longint acc_m [2];
    longint coef_m [8];

    always #10 clk = ~clk;

    vpm_slice u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_valid(in_valid),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .preadd_en(preadd_en),
        .coef_use(coef_use), .coef_sel(coef_sel), .coef_we(coef_we),
        .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .acc_sel(acc_sel),
        .acc_clr(acc_clr), .casc_in(casc_in), .out_valid(out_valid),
        .result(result), .casc_out(casc_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint product_term(input logic [1:0] m, input logic [35:0] x,
            input logic [37:0] y, input logic [35:0] z, input bit pre, input bit cu,
            input longint cf);
        longint a, b, a1, b1;
        if (m == 2'b01) begin
            a  = longint'($signed(x[17:0]))  + (pre ? longint'($signed(z[17:0]))  : 0);
            a1 = longint'($signed(x[35:18])) + (pre ? longint'($signed(z[35:18])) : 0);
            b  = cu ? cf : longint'($signed(y[18:0]));
            b1 = cu ? cf : longint'($signed(y[37:19]));
            return a * b + a1 * b1;
        end
        a = longint'($signed(x[26:0])) + (pre ? longint'($signed(z[26:0])) : 0);
        b = cu ? cf : longint'($signed(y[26:0]));
        return a * b;
    endfunction

    // One operand set; checks latency (R2), result and cascade output (R11).
    task automatic op(input string req, input logic [1:0] m, input logic [35:0] x,
            input logic [37:0] y, input logic [35:0] z, input bit pre, input bit cu,
            input logic [2:0] sel, input bit asel, input bit clr, input logic [63:0] casc);
        logic [63:0] exp;
        longint p0, p1, p2;
        @(negedge clk);
        cfg_mode = m; x_in = x; y_in = y; z_in = z; preadd_en = pre; coef_use = cu;
        coef_sel = sel; acc_sel = asel; acc_clr = clr; casc_in = casc; in_valid = 1'b1;
        if (m == 2'b00) begin
            p0 = longint'($signed(x[8:0]))   * longint'($signed(y[8:0]));
            p1 = longint'($signed(x[17:9]))  * longint'($signed(y[17:9]));
            p2 = longint'($signed(x[26:18])) * longint'($signed(y[26:18]));
            exp = {10'd0, 18'(p2), 18'(p1), 18'(p0)};
        end else begin
            acc_m[asel] = (clr ? 64'sd0 : acc_m[asel])
                        + product_term(m, x, y, z, pre, cu, coef_m[sel]) + longint'(casc);
            exp = 64'(acc_m[asel]);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R2 early"}, {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check({req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
        check({req, " R11 casc_out"}, casc_out, exp);
    endtask

    task automatic write_coef(input logic [2:0] a, input logic [17:0] d);
        @(negedge clk);
        coef_we = 1'b1; coef_waddr = a; coef_wdata = d;
        @(negedge clk);
        coef_we = 1'b0;
        coef_m[a] = longint'($signed(d));
    endtask

    task automatic t_reset();
        // R1
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        check("R1 casc_out", casc_out, 64'd0);
    endtask

    task automatic t_triple();
        // R3 lanes, R6 and R7 have no effect in narrow mode
        op("R3 R6 R7 triple", 2'b00,
           {9'd0, 9'sd100, -9'sd2, 9'sd3},
           {11'd0, -9'sd128, 9'sd7, 9'sd5},
           36'h0_1234_5678, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 64'h1111_2222_3333_4444);
        @(negedge clk);
        check("R2 hold", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_single();
        // R5 and R9
        op("R5 R9 single27 clr", 2'b10, {9'd0, -27'sd5000000}, {11'd0, 27'sd12345678},
           36'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 64'd0);
    endtask

    task automatic t_dual_acc();
        // R4 and R8: accumulate onto the single-mode sum
        op("R4 R8 dual accumulate", 2'b01, {18'sd77777, -18'sd100000},
           {-19'sd150000, 19'sd200000}, 36'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 64'd0);
    endtask

    task automatic t_preadd();
        // R6 in both wide modes, full-scale operands
        op("R6 dual preadd", 2'b01, {-18'sd131072, 18'sd131071},
           {19'sd262143, -19'sd262144}, {-18'sd131072, 18'sd30000},
           1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 64'd0);
        op("R6 single preadd", 2'b10, {9'd0, 27'sd67108863}, {11'd0, -27'sd67108864},
           {9'd0, 27'sd67108863}, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 64'd0);
    endtask

    task automatic t_coef();
        // R7: stored coefficients replace the y operand
        write_coef(3'd3, -18'sd1000);
        write_coef(3'd7, 18'sd131071);
        op("R7 dual coef", 2'b01, {18'sd1234, -18'sd4321}, 38'h3F_FFFF_FFFF,
           36'd0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 64'd0);
        op("R7 single coef", 2'b10, {9'd0, -27'sd3000000}, 38'd99, 36'd0,
           1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 64'd0);
    endtask

    task automatic t_double_acc();
        // R10 and R11: second sum loaded with cascade, first sum untouched
        op("R10 R11 sum1 load", 2'b10, {9'd0, 27'sd1000}, {11'd0, 27'sd2000}, 36'd0,
           1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0);
        op("R10 sum0 continues", 2'b10, {9'd0, 27'sd3}, {11'd0, 27'sd4}, 36'd0,
           1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 64'd0);
        op("R10 R11 sum1 continues", 2'b01, {18'sd5, 18'sd6}, {19'sd7, 19'sd8}, 36'd0,
           1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF00);
    endtask

    task automatic t_triple_isolation();
        // R3: narrow-mode traffic leaves the running sums alone
        op("R3 triple again", 2'b00, {9'd0, -9'sd256, -9'sd256, 9'sd255},
           {11'd0, -9'sd256, 9'sd1, -9'sd256}, 36'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0,
           64'hDEAD_BEEF_0000_0001);
        op("R3 R8 sum0 unchanged", 2'b10, {9'd0, 27'sd1}, {11'd0, 27'sd1}, 36'd0,
           1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 64'd0);
    endtask

    initial begin
        acc_m = '{0, 0};
        foreach (coef_m[i]) coef_m[i] = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_triple();
        t_single();
        t_dual_acc();
        t_preadd();
        t_coef();
        t_double_acc();
        t_triple_isolation();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule